// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM built around a small parameterized word array. Every input is captured on the rising clock edge: address, command, write data and lane enables. Read and write commands may follow each other in any order on consecutive cycles, with no idle cycle between them. This works because write data is deferred: it is sampled two enabled cycles after its command, which is the same stage where read data reaches the output.

A load cycle starts a new operation from an external address. An advance cycle repeats the previous operation at the next address of a four-beat burst, in either linear or interleaved order. A stall input freezes the whole pipeline. An output-enable input and a sleep input gate the read port asynchronously.

Read data leaves the block as a stream, `rdata_o` qualified by `rvalid_o`. The stream has no ready input. A consumer that cannot accept a beat must hold the block with `stall_i` before issuing the command, because beats already in the pipeline cannot be refused. Write data has no handshake: it is taken on a fixed schedule.

Top module: `nws_sram`

## Requirements
- R1: The block is selected only when `cs1_n_i`=0, `cs2_i`=1 and `cs3_n_i`=0 on a load cycle (`adv_i`=0). Every other combination on a load cycle is a deselect, which performs no access and produces no read beat.
- R2: A read command registered on enabled edge k drives the stored word on `rdata_o`, with `rvalid_o`=1, after enabled edge k+2. While `rvalid_o` is 0, `rdata_o` reads zero.
- R3: For a write command registered on enabled edge k, the write data and byte-lane enables (active low, lane n = bits n*LANE_W upward) are sampled at enabled edge k+2. Only the lanes whose enable is 0 are updated. The lane enables are ignored on cycles with no write in that stage.
- R4: A write beat with every lane enable at 1 stores nothing, and the burst still steps past that beat.
- R5: With `adv_i`=1 the previous command (read, write or deselect) continues at the next burst address. Address bits above the low two keep their loaded value, and the 2-bit beat count wraps after four beats.
- R6: With `ilv_i`=0, beat n of a burst that starts at low bits s uses low bits (s+n) mod 4.
- R7: With `ilv_i`=1, beat n of a burst that starts at low bits s uses low bits s XOR n.
- R8: While `stall_i`=1, all synchronous inputs are ignored. The pipeline, the array and the output register keep their values.
- R9: An advance cycle that follows a deselect continues the deselect and performs no access.
- R10: Reads and writes may alternate on every enabled cycle, and each read returns the contents left by all writes issued before it.
- R11: A read issued on the cycle right after a write to the same address returns the merged word. Lanes enabled by that write carry its data, and the other lanes carry the earlier contents.
- R12: When `oe_n_i`=1 or `sleep_i`=1, `rdata_o` is zero and `rvalid_o` is 0 at once, without a clock edge. The pipeline is not disturbed.
- R13: During and after reset, with no command issued, `rvalid_o`=0 and `rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline and burst state |
| stall_i | input | 1 | 1 suspends all clocked activity |
| cs1_n_i | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| cs3_n_i | input | 1 | Chip select, active low |
| adv_i | input | 1 | 0 loads a new address and command; 1 advances the burst |
| read_i | input | 1 | On a load cycle: 1 read, 0 write |
| addr_i | input | ADDR_W | Word address; the low two bits set the burst start |
| lane_we_n_i | input | LANES | Active-low write enable per byte lane (data phase) |
| wdata_i | input | LANES*LANE_W | Write data (data phase) |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous output shutoff |
| ilv_i | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| rdata_o | output | LANES*LANE_W | Read data beat |
| rvalid_o | output | 1 | Read beat valid |

## Verification
The bench builds the block with ADDR_W=5, LANES=2 and LANE_W=8. A 32-word array can be filled and read back in full within a few dozen cycles. Two lanes are enough to produce every partial-write and partial-forward pattern (lane 0 only, lane 1 only, both, neither). With ADDR_W=5 the low two bits still span all four burst starts, so every start offset can be walked in both burst orders, including the wrap on the fifth beat.

// File: rtl/nws_pkg.sv
`timescale 1ns/1ps
package nws_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  localparam int BURST_W = 2;
endpackage

// File: rtl/nws_burst.sv
`timescale 1ns/1ps
module nws_burst #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          step,
  input  logic          ilv,
  input  logic [BW-1:0] base_in,
  output logic [BW-1:0] off_o
);
  logic [BW-1:0] base_q;
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      if (load) begin
        base_q <= base_in;
        cnt_q  <= '0;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Beat offset: XOR walk or modular add of the running count
  assign off_o = ilv ? (base_q ^ cnt_q) : (base_q + cnt_q);

  // R5
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> (off_o == $past(base_in)));
endmodule

// File: rtl/nws_array.sv
`timescale 1ns/1ps
module nws_array #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       waddr,
  input  logic [LANES-1:0]    lane_we_n,
  input  logic [LANES*LW-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic [LANES*LW-1:0] rd_merged
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          hit;

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_en && !lane_we_n[l]) mem[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
    end
  end

  // A write committing on this edge targets the word being read
  assign hit = wr_en && (waddr == raddr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_merged[g*LW +: LW] = (hit && !lane_we_n[g]) ? wdata[g*LW +: LW]
                                                          : mem[raddr][g*LW +: LW];
  end

  // R4
  abort_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&lane_we_n)) |=> (mem[$past(waddr)] == $past(mem[waddr])));
endmodule

// File: rtl/nws_sram.sv
`timescale 1ns/1ps
module nws_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall_i,
  input  logic                    cs1_n_i,
  input  logic                    cs2_i,
  input  logic                    cs3_n_i,
  input  logic                    adv_i,
  input  logic                    read_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        lane_we_n_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_n_i,
  input  logic                    sleep_i,
  input  logic                    ilv_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  import nws_pkg::*;

  localparam int DW   = LANES * LANE_W;
  localparam int HI_W = ADDR_W - BURST_W;

  logic en, load, sel;
  assign en   = !stall_i;
  assign load = !adv_i;
  assign sel  = !cs1_n_i && cs2_i && !cs3_n_i;

  // Stage A: command and upper address; low bits come from the burst walker
  op_e                a_cmd;
  logic [HI_W-1:0]    a_hi;
  logic [BURST_W-1:0] a_off;
  logic [ADDR_W-1:0]  a_addr;
  // Stage B: access stage, write commit and read capture
  op_e                b_cmd;
  logic [ADDR_W-1:0]  b_addr;
  logic [DW-1:0]      hold_q;
  logic [DW-1:0]      merged;
  // Output register
  logic [DW-1:0]      out_q;
  logic               outv_q;

  assign a_addr = {a_hi, a_off};

  nws_burst #(.BW(BURST_W)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .load    (load),
    .step    (adv_i),
    .ilv     (ilv_i),
    .base_in (addr_i[BURST_W-1:0]),
    .off_o   (a_off)
  );

  nws_array #(.AW(ADDR_W), .LANES(LANES), .LW(LANE_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (en && (b_cmd == OP_WR)),
    .waddr     (b_addr),
    .lane_we_n (lane_we_n_i),
    .wdata     (wdata_i),
    .raddr     (a_addr),
    .rd_merged (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_cmd  <= OP_IDLE;
      a_hi   <= '0;
      b_cmd  <= OP_IDLE;
      b_addr <= '0;
      hold_q <= '0;
      out_q  <= '0;
      outv_q <= 1'b0;
    end else if (en) begin
      if (load) begin
        a_cmd <= sel ? (read_i ? OP_RD : OP_WR) : OP_IDLE;
        a_hi  <= addr_i[ADDR_W-1:BURST_W];
      end
      b_cmd  <= a_cmd;
      b_addr <= a_addr;
      hold_q <= merged;
      outv_q <= (b_cmd == OP_RD);
      out_q  <= (b_cmd == OP_RD) ? hold_q : '0;
    end
  end

  assign rdata_o  = (oe_n_i || sleep_i) ? '0 : out_q;
  assign rvalid_o = outv_q && !oe_n_i && !sleep_i;

  // R1
  desel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load && !sel) |=> (a_cmd == OP_IDLE));

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(out_q) && $stable(outv_q) && $stable(b_cmd) && $stable(hold_q)));

  // R12
  gated_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |-> (!oe_n_i && !sleep_i));

  // R2
  quiet_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_o |-> (rdata_o == '0));
endmodule

// File: tb/sim_nws_sram.sv
`timescale 1ns/1ps
module sim_nws_sram;
  localparam int AW    = 5;
  localparam int LN    = 2;
  localparam int LW    = 8;
  localparam int DW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall_i = 1'b0;
  logic          cs1_n_i = 1'b1, cs2_i = 1'b0, cs3_n_i = 1'b1;
  logic          adv_i = 1'b0, read_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [LN-1:0] lane_we_n_i = '1;
  logic [DW-1:0] wdata_i = '0;
  logic          oe_n_i = 1'b0, sleep_i = 1'b0, ilv_i = 1'b0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;

  nws_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .cs1_n_i(cs1_n_i), .cs2_i(cs2_i), .cs3_n_i(cs3_n_i),
    .adv_i(adv_i), .read_i(read_i), .addr_i(addr_i),
    .lane_we_n_i(lane_we_n_i), .wdata_i(wdata_i),
    .oe_n_i(oe_n_i), .sleep_i(sleep_i), .ilv_i(ilv_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  always #2 clk = ~clk;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  // Transaction-level reference: array updated at issue time
  logic [DW-1:0]   ref_mem [DEPTH];
  int              m_cmd = 0;
  logic [AW-3:0]   m_hi = '0;
  logic [1:0]      m_base = '0, m_cnt = '0;
  logic            ilv_m = 1'b0;
  logic            pv [3];
  logic [DW-1:0]   pd [3];
  logic            wv [2];
  logic [DW-1:0]   wd [2];
  logic [LN-1:0]   wm [2];
  int              wcnt = 0;

  task automatic chk(input string tag, input logic [DW-1:0] ad, input logic av,
                     input logic [DW-1:0] ed, input logic ev);
    checks++;
    if (ad !== ed || av !== ev) begin
      errs++;
      $display("FAIL %s: got data=%h valid=%b, expected data=%h valid=%b", tag, ad, av, ed, ev);
    end
  endtask

  task automatic cyc(input string tag, input logic st, input logic c1n, input logic c2,
                     input logic c3n, input logic adv, input logic rd, input logic [AW-1:0] a,
                     input logic [LN-1:0] mn, input logic o_n, input logic sl);
    logic [AW-1:0] ea;
    logic [DW-1:0] d;
    @(negedge clk);
    stall_i = st; cs1_n_i = c1n; cs2_i = c2; cs3_n_i = c3n;
    adv_i = adv; read_i = rd; addr_i = a; oe_n_i = o_n; sleep_i = sl; ilv_i = ilv_m;
    if (st) begin
      wdata_i = 16'hBEEF; lane_we_n_i = '0;
    end else if (wv[1]) begin
      wdata_i = wd[1]; lane_we_n_i = wm[1];
    end else begin
      wdata_i = 16'hDEAD; lane_we_n_i = '0;
    end
    if (!st) begin
      if (!adv) begin
        m_cmd  = (!c1n && c2 && !c3n) ? (rd ? 1 : 2) : 0;
        m_hi   = a[AW-1:2];
        m_base = a[1:0];
        m_cnt  = '0;
      end else begin
        m_cnt = m_cnt + 2'd1;
      end
      ea = {m_hi, (ilv_m ? (m_base ^ m_cnt) : 2'(m_base + m_cnt))};
      pv[2] = pv[1]; pd[2] = pd[1]; pv[1] = pv[0]; pd[1] = pd[0];
      wv[1] = wv[0]; wd[1] = wd[0]; wm[1] = wm[0];
      wv[0] = 1'b0; pv[0] = 1'b0; pd[0] = '0;
      if (m_cmd == 2) begin
        wcnt++;
        d = 16'(wcnt * 16'h2B47 + 16'h1111);
        for (int l = 0; l < LN; l++)
          if (!mn[l]) ref_mem[ea][l*LW +: LW] = d[l*LW +: LW];
        wv[0] = 1'b1; wd[0] = d; wm[0] = mn;
      end else if (m_cmd == 1) begin
        pv[0] = 1'b1; pd[0] = ref_mem[ea];
      end
    end
    @(posedge clk);
    #1;
    chk(tag, rdata_o, rvalid_o, (pv[2] && !o_n && !sl) ? pd[2] : '0, pv[2] && !o_n && !sl);
  endtask

  task automatic wr(input string tag, input logic [AW-1:0] a, input logic [LN-1:0] mn);
    cyc(tag, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, mn, 1'b0, 1'b0);
  endtask
  task automatic rd(input string tag, input logic [AW-1:0] a);
    cyc(tag, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, a, '1, 1'b0, 1'b0);
  endtask
  task automatic step(input string tag, input logic [LN-1:0] mn);
    cyc(tag, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd31, mn, 1'b0, 1'b0);
  endtask
  task automatic idle(input string tag);
    cyc(tag, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '0, '1, 1'b0, 1'b0);
  endtask
  task automatic hold(input string tag);
    cyc(tag, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd3, '0, 1'b0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pd[i] = '0; end
    for (int i = 0; i < 2; i++) begin wv[i] = 1'b0; wd[i] = '0; wm[i] = '1; end
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R13: reset state with output enabled
    chk("R13", rdata_o, rvalid_o, '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R13");
    idle("R13");

    // R3: full-array fill, then R2: full read-back
    for (int a = 0; a < DEPTH; a++) wr("R3", 5'(a), 2'b00);
    idle("R3"); idle("R3");
    for (int a = 0; a < DEPTH; a++) rd("R2", 5'(a));
    idle("R2"); idle("R2");

    // R10: read/write alternation every cycle, varied lane masks
    for (int i = 0; i < 16; i++) begin
      wr("R10", 5'(i), (i % 3 == 0) ? 2'b00 : ((i % 3 == 1) ? 2'b01 : 2'b10));
      rd("R10", 5'(i * 5 + 3));
    end
    idle("R10"); idle("R10");

    // R11: read right behind a write to the same word, each lane pattern
    for (int k = 0; k < 3; k++) begin
      wr("R11", 5'd9, (k == 0) ? 2'b00 : ((k == 1) ? 2'b01 : 2'b10));
      rd("R11", 5'd9);
      idle("R11"); idle("R11");
    end

    // R4: write abort, single beat and inside a burst
    wr("R4", 5'd4, 2'b11);
    rd("R4", 5'd4);
    idle("R4"); idle("R4");
    wr("R4", 5'd16, 2'b00); step("R4", 2'b11); step("R4", 2'b00); step("R4", 2'b10);
    idle("R4");
    rd("R4", 5'd16); step("R4", 2'b11); step("R4", 2'b11); step("R4", 2'b11);
    idle("R4"); idle("R4");

    // R5/R6/R7: every start offset in both orders, fifth beat wraps
    for (int md = 0; md < 2; md++) begin
      ilv_m = md[0];
      idle("R5");
      for (int s = 0; s < 4; s++) begin
        rd((md == 1) ? "R7" : "R6", {3'(s + 2), 2'(s)});
        for (int b = 0; b < 4; b++) step((b == 3) ? "R5" : ((md == 1) ? "R7" : "R6"), 2'b11);
        idle("R5"); idle("R5");
      end
    end
    ilv_m = 1'b0;
    idle("R5");

    // R1 and R9: every non-selecting enable combination, then advance
    for (int c = 0; c < 8; c++) begin
      if (c != 2) begin
        cyc("R1", 1'b0, c[2], c[1], c[0], 1'b0, 1'b1, 5'(c), '1, 1'b0, 1'b0);
        cyc("R9", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd0, '1, 1'b0, 1'b0);
        cyc("R9", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0, '0, 1'b0, 1'b0);
      end
    end
    idle("R9"); idle("R9");

    // R8: stall freezes output and pipeline; junk on inputs ignored
    rd("R8", 5'd5); rd("R8", 5'd6); idle("R8");
    hold("R8"); hold("R8"); hold("R8");
    idle("R8"); idle("R8");
    wr("R8", 5'd20, 2'b00);
    hold("R8"); hold("R8");
    idle("R8"); idle("R8");
    rd("R8", 5'd20); idle("R8"); idle("R8");

    // R12: output gating, clocked and mid-cycle
    rd("R12", 5'd7); rd("R12", 5'd8);
    cyc("R12", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '0, '1, 1'b1, 1'b0);
    cyc("R12", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '0, '1, 1'b0, 1'b1);
    rd("R12", 5'd7); idle("R12"); idle("R12");
    #0.5 oe_n_i = 1'b1;
    #0.2 chk("R12", rdata_o, rvalid_o, '0, 1'b0);
    oe_n_i = 1'b0;
    #0.2 chk("R12", rdata_o, rvalid_o, pd[2], 1'b1);
    sleep_i = 1'b1;
    #0.2 chk("R12", rdata_o, rvalid_o, '0, 1'b0);
    sleep_i = 1'b0;
    idle("R12"); idle("R12");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule